// File: doc/BRIEF.md
# Serial Word Transmitter (SPI Master, Write Only)

This block sends one 16-bit word to a single peripheral over a three-wire SPI link: an active-low select, a serial clock that rests low, and a data-out line. The host presents the word and a programmable half-period, then pulses a one-cycle send strobe. The block lowers the select line, puts the least significant bit on the data line, and toggles the serial clock sixteen times. It presents each following bit as the clock falls and releases the select line only after the final low phase.

The serial clock comes from explicit phase states: select, first-data, clock-high, clock-low-with-next-bit and deselect. Each phase lasts a fixed number of system clocks, set by the half-period value latched at the strobe. An abort input ends any transfer at the next clock edge and returns every pin to rest. A busy flag covers the whole transfer, and a done pulse marks each normal completion.

Top module: `spi_word_tx`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and done is 0, and the block stays in this rest state until a send strobe arrives.
- R2: A send strobe sampled while idle makes cs_n 0 and busy 1 in the next cycle. cs_n then stays 0 and busy stays 1 until the transfer ends, and busy equals the inverse of cs_n at all times.
- R3: A transfer makes exactly 16 rising edges of sclk. Before rising edge k (k = 0..15), mosi carries bit k of the word, so bit 0 is sent first. mosi does not change while sclk is high.
- R4: With H = max(half_ticks, 1), taken at the strobe, every phase lasts exactly H system clocks. The phases run in this order: select (sclk 0, mosi 0), first data (mosi = bit 0), then clock-high and clock-low alternating, and finally deselect (sclk 0, cs_n still 0).
- R5: The change of mosi to bit k+1 happens in the same cycle as the falling edge of sclk that ends bit k, for k = 0..14. After the falling edge of bit 15, mosi holds bit 15 through the deselect phase.
- R6: On normal completion, cs_n returns to 1, busy goes to 0, mosi goes to 0 and done is 1 for exactly one cycle. This happens 34·H cycles after the first cycle in which cs_n is 0.
- R7: A send strobe that arrives while busy is 1 is ignored. The transfer in progress and its word are unchanged.
- R8: An abort sampled while busy makes cs_n 1, sclk 0, mosi 0 and busy 0 in the next cycle, with no done pulse.
- R9: An abort sampled while idle has no effect on any output.
- R10: A half_ticks value of 0 gives the same waveform as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 16 | Word to send, taken at the strobe |
| half_ticks | input | 16 | Serial clock half-period in system clocks, taken at the strobe |
| send | input | 1 | One-cycle start strobe |
| abort | input | 1 | Ends the current transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| cs_n | output | 1 | Active-low peripheral select |
| sclk | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data out |

## Verification
The properties assume that send and abort are synchronous to clk and settle away from its rising edge. They also assume that only abort can shorten a transfer. The bench drives every input on the falling edge, holds send and abort for whole cycles, and keeps half_ticks constant for the length of each transfer. It sweeps half-periods 0 to 3 over several data patterns. It compares every output on every cycle against a waveform computed from the cycle index, and it places aborts in several phases, including idle.

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int WORD_W = 16,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic [TICK_W-1:0] half_ticks,
  input  logic              send,
  input  logic              abort,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi
);
  localparam int IDX_W = $clog2(WORD_W);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_DATA, S_HIGH, S_LOW, S_DESEL} st_t;

  st_t               st;
  logic [WORD_W-1:0] word;
  logic [TICK_W-1:0] half_q, cnt;
  logic [IDX_W-1:0]  idx;

  wire phase_end = (cnt == half_q - 1'b1);
  wire last_bit  = (idx == IDX_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      word   <= '0;
      half_q <= TICK_W'(1);
      cnt    <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (send) begin
          word   <= tx_data;
          half_q <= (half_ticks == '0) ? TICK_W'(1) : half_ticks;
          cnt    <= '0;
          idx    <= '0;
          st     <= S_SEL;
          cs_n   <= 1'b0;
          busy   <= 1'b1;
        end
      end else if (abort) begin
        st   <= S_IDLE;
        cs_n <= 1'b1;
        sclk <= 1'b0;
        mosi <= 1'b0;
        busy <= 1'b0;
      end else if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_SEL: begin
            st   <= S_DATA;
            mosi <= word[0];
          end
          S_DATA, S_LOW: begin
            st   <= S_HIGH;
            sclk <= 1'b1;
          end
          S_HIGH: begin
            sclk <= 1'b0;
            if (last_bit) begin
              st <= S_DESEL;
            end else begin
              st   <= S_LOW;
              mosi <= word[1];
              word <= word >> 1;
              idx  <= idx + 1'b1;
            end
          end
          S_DESEL: begin
            st   <= S_IDLE;
            cs_n <= 1'b1;
            mosi <= 1'b0;
            busy <= 1'b0;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_word_tx_chk.sv
module spi_word_tx_chk #(
  parameter int WORD_W = 16,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] tx_data,
  input logic [TICK_W-1:0] half_ticks,
  input logic              send,
  input logic              abort,
  input logic              busy,
  input logic              done,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi
);
  // R2
  busy_matches_select_chk: assert property (@(posedge clk) disable iff (!rst_n) busy == !cs_n);
  // R2
  start_on_send_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy && send |=> busy && !cs_n);
  // R3
  mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk && $past(sclk) |-> $stable(mosi));
  // R4
  sclk_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_at_rest_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n && !busy && !sclk && !mosi);
  // R8
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && abort |=> cs_n && !sclk && !mosi && !busy && !done);
  // R9
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy && !send && abort |=> !busy && cs_n && !sclk && !mosi);
endmodule

bind spi_word_tx spi_word_tx_chk #(.WORD_W(WORD_W), .TICK_W(TICK_W)) u_chk (.*);

// File: tb/sim_spi_word_tx.sv
`timescale 1ns/1ps
module sim_spi_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_data = '0;
  logic [15:0] half_ticks = '0;
  logic        send = 1'b0;
  logic        abort = 1'b0;
  logic        busy, done, cs_n, sclk, mosi;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spi_word_tx u0 (.clk, .rst_n, .tx_data, .half_ticks, .send, .abort,
                  .busy, .done, .cs_n, .sclk, .mosi);

  function automatic logic [4:0] expect_pins(int n, int h, logic [15:0] d);
    int s = (n - 1) / h;
    logic c = 1'b0, k = 1'b0, m = 1'b0, b = 1'b1, dn = 1'b0;
    if (s == 1) m = d[0];
    else if (s >= 2 && s <= 32 && s % 2 == 0) begin k = 1'b1; m = d[(s - 2) / 2]; end
    else if (s >= 3 && s <= 31) m = d[(s - 3) / 2 + 1];
    else if (s == 33) m = d[15];
    else if (s >= 34) begin c = 1'b1; b = 1'b0; dn = ((n - 1) == 34 * h); end
    return {c, k, m, b, dn};
  endfunction

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act = {cs_n, sclk, mosi, busy, done};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t cs_n/sclk/mosi/busy/done actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // abort_at = 0 means no abort; ext = effective H used for expectation
  task automatic xfer(logic [15:0] d, int h, int abort_at, string req);
    int he = (h == 0) ? 1 : h;
    @(negedge clk);
    tx_data = d; half_ticks = 16'(h); send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    for (int n = 1; n <= 34 * he + 3; n++) begin
      // R7: stray strobe with other data while busy
      if (n == 3) begin send = 1'b1; tx_data = ~d; end
      if (n == 4) begin send = 1'b0; tx_data = d; end
      check(req, expect_pins(n, he, d));
      if (abort_at != 0 && n == abort_at) begin
        abort = 1'b1;
        for (int j = 0; j < 3; j++) begin
          @(negedge clk);
          check("R8", 5'b10000);
        end
        abort = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 5'b10000);
    // R9: abort while idle
    abort = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check("R9", 5'b10000);
    end
    abort = 1'b0;
    for (int h = 0; h <= 3; h++) begin
      xfer(16'hA5C3, h, 0, (h == 0) ? "R10" : "R3");
      xfer(16'hFFFF, h, 0, "R4");
      xfer(16'h0001, h, 0, "R5");
      xfer(16'h8000, h, 0, "R6");
      xfer(16'h3C96, h, 0, "R2");
    end
    // R8: aborts in different phases
    xfer(16'h1234, 2, 1, "R8");
    xfer(16'h5678, 2, 6, "R8");
    xfer(16'h9ABC, 3, 50, "R8");
    xfer(16'hDEF0, 1, 33, "R8");
    // transfer after abort runs normally
    xfer(16'h6B2D, 2, 0, "R2");
    report();
  end
endmodule